// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit performs the architectural bookkeeping of a return from a trap handler. It supports three return flavours: supervisor return, machine return and return from a resumable non-maskable interrupt. On each request it reads the current privilege level and virtualization flag, the machine status word, the hypervisor status bits, the virtual-supervisor double-trap bit, the NMI status word, the current expected-landing-pad flag and the three saved return addresses. It then produces the new status values, the new privilege and virtualization state, the return PC, and a trap indication with its cause when the return is not allowed.

The caller pulses `req_valid` together with the flavour code and the input state. The unit registers the result, so exactly one cycle later `out_valid` pulses for one cycle with the complete result. A request is accepted on every cycle and there is no back-pressure. The caller writes the outputs back into its state when `out_valid` is high and `trap` is low. When a trap is reported, every state output equals the corresponding input, so writing it back changes nothing. Register-file access and pipeline flushing belong to the caller.

Top module: `trap_return_unit`

## Requirements
- R1: Encodings are as follows. Privilege is U=0, S=1, M=3. `req_kind` is 0 for supervisor return, 1 for machine return, 2 for NMI return, and 3 is reserved and always traps as illegal. Trap causes are 0 for misaligned PC, 1 for fetch access fault, 2 for illegal instruction and 22 for virtual instruction. The `m_status` bits are: 0 s_ie, 1 m_ie, 2 s_pie, 3 m_pie, 4 s_pp, 6:5 m_pp, 7 mprv, 8 tsr, 9 m_pv, 10 s_dt, 11 m_dt, 12 s_elp, 13 m_elp. The `h_status` bits are: 0 s_pv, 1 vtsr. The `n_status` bits are: 0 nmi_en, 2:1 n_pp, 3 n_pv, 4 n_elp.
- R2: `out_valid` is high for exactly the one cycle that follows a cycle with `req_valid` high, and it is low at every other time.
- R3: A supervisor return with privilege below S traps with cause 2. A machine or NMI return with privilege other than M also traps with cause 2. This check has the highest priority.
- R4: When `cfg_rvc` is 0 and bits [1:0] of the selected return PC are nonzero, the return traps with cause 0 (second priority). When `cfg_rvc` is 1, those bits cause no trap.
- R5: A supervisor return traps with cause 2 when tsr is set and the privilege is not M. Otherwise it traps with cause 22 when virtualization is on and vtsr is set.
- R6: A supervisor return copies s_pie into s_ie, sets s_pie, takes the new privilege from s_pp (1 gives S, 0 gives U) and clears s_pp.
- R7: A machine return copies m_pie into m_ie, sets m_pie, and clears m_pv. It sets m_pp to U when `cfg_rvu` is 1 and to M otherwise. The new privilege is the old m_pp. An NMI return takes the new privilege from n_pp.
- R8: For machine and NMI returns, the new virtualization state is m_pv or n_pv respectively, forced to 0 when the new privilege is M. For a supervisor return with `cfg_rvh` set and virtualization off, the new state is s_pv and s_pv is cleared. Otherwise a supervisor return keeps the current state.
- R9: When `cfg_v112` is set, a supervisor return clears mprv, and a machine return clears mprv when its new privilege is not M. An NMI return clears mprv whenever its new privilege is not M, regardless of `cfg_v112`.
- R10: An NMI return sets nmi_en. Machine and NMI returns trap with cause 1 (third priority) when `cfg_pmp_empty` is set and the new privilege is not M.
- R11: With `cfg_sdbl`, a supervisor return clears s_dt, and also clears `vs_sdt` when `cfg_rvh` is set, virtualization is off, s_pv is 1 and s_pp is 0. With `cfg_sdbl`, machine and NMI returns clear s_dt when the target is U, or when the new virtualization state is 1 and the target is U or S; they clear `vs_sdt` when the new virtualization state is 1 and the target is U. With `cfg_mdbl`, m_dt is cleared by every machine return, by a supervisor return from M, and by an NMI return to a privilege other than M.
- R12: The flavour's saved landing-pad bit (s_elp, m_elp or n_elp) is copied to `elp_o` when `lpad_en[new privilege]` is set; otherwise `elp_o` equals `elp_i`. The saved bit is always cleared.
- R13: On a trap, every state output equals its input: privilege, virtualization, all status words, `vs_sdt` and elp.
- R14: After reset, `out_valid` and `trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Return request strobe |
| req_kind | input | 2 | Return flavour |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization flag |
| m_status_i | input | 14 | Machine status word |
| h_status_i | input | 2 | Hypervisor status bits |
| vs_sdt_i | input | 1 | Virtual-supervisor double-trap bit |
| n_status_i | input | 5 | NMI status word |
| elp_i | input | 1 | Current expected-landing-pad flag |
| s_epc_i | input | XLEN | Supervisor return address |
| m_epc_i | input | XLEN | Machine return address |
| n_epc_i | input | XLEN | NMI return address |
| cfg_rvc | input | 1 | Compressed instructions supported |
| cfg_rvu | input | 1 | User mode supported |
| cfg_rvh | input | 1 | Hypervisor present |
| cfg_sdbl | input | 1 | Supervisor double-trap extension |
| cfg_mdbl | input | 1 | Machine double-trap extension |
| cfg_v112 | input | 1 | Privilege spec version 1.12 or later |
| cfg_pmp_empty | input | 1 | PMP present with zero rules |
| lpad_en | input | 4 | Forward-CFI enable, indexed by privilege |
| out_valid | output | 1 | Result strobe |
| trap | output | 1 | Return refused |
| trap_cause | output | 5 | Trap cause |
| new_priv | output | 2 | Privilege after return |
| new_virt | output | 1 | Virtualization after return |
| m_status_o | output | 14 | Updated machine status |
| h_status_o | output | 2 | Updated hypervisor status |
| vs_sdt_o | output | 1 | Updated virtual double-trap bit |
| n_status_o | output | 5 | Updated NMI status |
| elp_o | output | 1 | Updated landing-pad flag |
| ret_pc | output | XLEN | Selected return address |

## Verification
Every result, including trap and cause, is due in the cycle that follows the `req_valid` cycle. The bench drives inputs on the falling edge, lets one rising edge capture them, and samples all outputs at the next falling edge. It then samples once more a cycle later to confirm that the strobe has dropped. Expected values come from a bench model of the rules, applied to random states and to directed corner cases for each flavour and priority.

// File: rtl/tret_pkg.sv
package tret_pkg;
  localparam int MS_W = 14;
  localparam int HS_W = 2;
  localparam int NS_W = 5;
  localparam int CAUSE_W = 5;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    K_SRET = 2'd0,
    K_MRET = 2'd1,
    K_NRET = 2'd2,
    K_RSVD = 2'd3
  } ret_kind_e;

  localparam logic [CAUSE_W-1:0] C_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] C_ACCESS   = 5'd1;
  localparam logic [CAUSE_W-1:0] C_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] C_VIRT     = 5'd22;

  localparam int B_SIE  = 0;
  localparam int B_MIE  = 1;
  localparam int B_SPIE = 2;
  localparam int B_MPIE = 3;
  localparam int B_SPP  = 4;
  localparam int B_MPP  = 5;
  localparam int B_MPRV = 7;
  localparam int B_TSR  = 8;
  localparam int B_MPV  = 9;
  localparam int B_SDT  = 10;
  localparam int B_MDT  = 11;
  localparam int B_SELP = 12;
  localparam int B_MELP = 13;

  localparam int H_SPV  = 0;
  localparam int H_VTSR = 1;

  localparam int N_NMIE = 0;
  localparam int N_NPP  = 1;
  localparam int N_NPV  = 3;
  localparam int N_NELP = 4;
endpackage

// File: rtl/tret_check.sv
module tret_check
  import tret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]         kind,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [MS_W-1:0]    m_status,
  input  logic [HS_W-1:0]    h_status,
  input  logic [NS_W-1:0]    n_status,
  input  logic [XLEN-1:0]    pc,
  input  logic               cfg_rvc,
  input  logic               cfg_pmp_empty,
  output logic               trap,
  output logic [CAUSE_W-1:0] cause
);
  logic       priv_ok;
  logic [1:0] target;

  always_comb begin
    target = (kind == K_MRET) ? m_status[B_MPP +: 2] : n_status[N_NPP +: 2];
    case (kind)
      K_SRET:  priv_ok = (priv == PRIV_S) || (priv == PRIV_M);
      K_MRET,
      K_NRET:  priv_ok = (priv == PRIV_M);
      default: priv_ok = 1'b0;
    endcase
  end

  always_comb begin
    trap  = 1'b0;
    cause = C_ILLEGAL;
    if (!priv_ok) begin
      trap = 1'b1;
    end else if (!cfg_rvc && (pc[1:0] != 2'b00)) begin
      trap  = 1'b1;
      cause = C_MISALIGN;
    end else if (kind == K_SRET) begin
      if (m_status[B_TSR] && (priv != PRIV_M)) begin
        trap = 1'b1;
      end else if (virt && h_status[H_VTSR]) begin
        trap  = 1'b1;
        cause = C_VIRT;
      end
    end else if (cfg_pmp_empty && (target != PRIV_M)) begin
      trap  = 1'b1;
      cause = C_ACCESS;
    end
  end
endmodule

// File: rtl/tret_next.sv
module tret_next
  import tret_pkg::*;
(
  input  logic [1:0]      kind,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic [MS_W-1:0] m_in,
  input  logic [HS_W-1:0] h_in,
  input  logic            vs_in,
  input  logic [NS_W-1:0] n_in,
  input  logic            elp_in,
  input  logic            cfg_rvu,
  input  logic            cfg_rvh,
  input  logic            cfg_sdbl,
  input  logic            cfg_mdbl,
  input  logic            cfg_v112,
  input  logic [3:0]      lpad_en,
  output logic [MS_W-1:0] m_out,
  output logic [HS_W-1:0] h_out,
  output logic            vs_out,
  output logic [NS_W-1:0] n_out,
  output logic [1:0]      priv_out,
  output logic            virt_out,
  output logic            elp_out
);
  logic saved_elp;
  logic pv;
  logic to_lower;

  always_comb begin
    m_out     = m_in;
    h_out     = h_in;
    vs_out    = vs_in;
    n_out     = n_in;
    priv_out  = priv;
    pv        = virt;
    saved_elp = 1'b0;
    to_lower  = 1'b0;
    case (kind)
      K_SRET: begin
        priv_out       = m_in[B_SPP] ? PRIV_S : PRIV_U;
        m_out[B_SIE]   = m_in[B_SPIE];
        m_out[B_SPIE]  = 1'b1;
        m_out[B_SPP]   = 1'b0;
        if (cfg_sdbl) begin
          m_out[B_SDT] = 1'b0;
          if (cfg_rvh && !virt && h_in[H_SPV] && !m_in[B_SPP]) vs_out = 1'b0;
        end
        if (cfg_mdbl && (priv == PRIV_M)) m_out[B_MDT] = 1'b0;
        if (cfg_v112) m_out[B_MPRV] = 1'b0;
        if (cfg_rvh && !virt) begin
          pv           = h_in[H_SPV];
          h_out[H_SPV] = 1'b0;
        end
        saved_elp      = m_in[B_SELP];
        m_out[B_SELP]  = 1'b0;
      end
      K_MRET, K_NRET: begin
        if (kind == K_MRET) begin
          priv_out        = m_in[B_MPP +: 2];
          to_lower        = (priv_out != PRIV_M);
          pv              = m_in[B_MPV] && to_lower;
          m_out[B_MIE]    = m_in[B_MPIE];
          m_out[B_MPIE]   = 1'b1;
          m_out[B_MPP +: 2] = cfg_rvu ? PRIV_U : PRIV_M;
          m_out[B_MPV]    = 1'b0;
          if (cfg_v112 && to_lower) m_out[B_MPRV] = 1'b0;
          if (cfg_mdbl) m_out[B_MDT] = 1'b0;
          saved_elp       = m_in[B_MELP];
          m_out[B_MELP]   = 1'b0;
        end else begin
          priv_out        = n_in[N_NPP +: 2];
          to_lower        = (priv_out != PRIV_M);
          pv              = n_in[N_NPV] && to_lower;
          n_out[N_NMIE]   = 1'b1;
          if (to_lower) m_out[B_MPRV] = 1'b0;
          if (cfg_mdbl && to_lower) m_out[B_MDT] = 1'b0;
          saved_elp       = n_in[N_NELP];
          n_out[N_NELP]   = 1'b0;
        end
        if (cfg_sdbl && ((priv_out == PRIV_U) ||
                         (pv && (priv_out == PRIV_S)))) begin
          m_out[B_SDT] = 1'b0;
          if (pv && (priv_out == PRIV_U)) vs_out = 1'b0;
        end
      end
      default: ;
    endcase
    virt_out = pv;
    elp_out  = lpad_en[priv_out] ? saved_elp : elp_in;
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import tret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  logic [MS_W-1:0]    m_status_i,
  input  logic [HS_W-1:0]    h_status_i,
  input  logic               vs_sdt_i,
  input  logic [NS_W-1:0]    n_status_i,
  input  logic               elp_i,
  input  logic [XLEN-1:0]    s_epc_i,
  input  logic [XLEN-1:0]    m_epc_i,
  input  logic [XLEN-1:0]    n_epc_i,
  input  logic               cfg_rvc,
  input  logic               cfg_rvu,
  input  logic               cfg_rvh,
  input  logic               cfg_sdbl,
  input  logic               cfg_mdbl,
  input  logic               cfg_v112,
  input  logic               cfg_pmp_empty,
  input  logic [3:0]         lpad_en,
  output logic               out_valid,
  output logic               trap,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [1:0]         new_priv,
  output logic               new_virt,
  output logic [MS_W-1:0]    m_status_o,
  output logic [HS_W-1:0]    h_status_o,
  output logic               vs_sdt_o,
  output logic [NS_W-1:0]    n_status_o,
  output logic               elp_o,
  output logic [XLEN-1:0]    ret_pc
);
  logic [XLEN-1:0]    pc_sel;
  logic               c_trap;
  logic [CAUSE_W-1:0] c_cause;
  logic [MS_W-1:0]    nx_m;
  logic [HS_W-1:0]    nx_h;
  logic               nx_vs;
  logic [NS_W-1:0]    nx_n;
  logic [1:0]         nx_priv;
  logic               nx_virt;
  logic               nx_elp;

  always_comb begin
    case (req_kind)
      K_SRET:  pc_sel = s_epc_i;
      K_MRET:  pc_sel = m_epc_i;
      default: pc_sel = n_epc_i;
    endcase
  end

  tret_check #(.XLEN(XLEN)) u_check (
    .kind(req_kind), .priv(cur_priv), .virt(cur_virt),
    .m_status(m_status_i), .h_status(h_status_i), .n_status(n_status_i),
    .pc(pc_sel), .cfg_rvc(cfg_rvc), .cfg_pmp_empty(cfg_pmp_empty),
    .trap(c_trap), .cause(c_cause)
  );

  tret_next u_next (
    .kind(req_kind), .priv(cur_priv), .virt(cur_virt),
    .m_in(m_status_i), .h_in(h_status_i), .vs_in(vs_sdt_i),
    .n_in(n_status_i), .elp_in(elp_i),
    .cfg_rvu(cfg_rvu), .cfg_rvh(cfg_rvh), .cfg_sdbl(cfg_sdbl),
    .cfg_mdbl(cfg_mdbl), .cfg_v112(cfg_v112), .lpad_en(lpad_en),
    .m_out(nx_m), .h_out(nx_h), .vs_out(nx_vs), .n_out(nx_n),
    .priv_out(nx_priv), .virt_out(nx_virt), .elp_out(nx_elp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap       <= 1'b0;
      trap_cause <= '0;
      new_priv   <= PRIV_M;
      new_virt   <= 1'b0;
      m_status_o <= '0;
      h_status_o <= '0;
      vs_sdt_o   <= 1'b0;
      n_status_o <= '0;
      elp_o      <= 1'b0;
      ret_pc     <= '0;
    end else if (req_valid) begin
      trap       <= c_trap;
      trap_cause <= c_trap ? c_cause : '0;
      ret_pc     <= pc_sel;
      new_priv   <= c_trap ? cur_priv   : nx_priv;
      new_virt   <= c_trap ? cur_virt   : nx_virt;
      m_status_o <= c_trap ? m_status_i : nx_m;
      h_status_o <= c_trap ? h_status_i : nx_h;
      vs_sdt_o   <= c_trap ? vs_sdt_i   : nx_vs;
      n_status_o <= c_trap ? n_status_i : nx_n;
      elp_o      <= c_trap ? elp_i      : nx_elp;
    end
  end
endmodule

// File: rtl/tret_chk.sv
module tret_chk
  import tret_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic [1:0]         cur_priv,
  input logic [MS_W-1:0]    m_status_i,
  input logic               out_valid,
  input logic               trap,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [1:0]         new_priv,
  input logic [MS_W-1:0]    m_status_o,
  input logic [NS_W-1:0]    n_status_o
);
  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid));

  // R13
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && trap) |-> (m_status_o == $past(m_status_i)) && (new_priv == $past(cur_priv)));

  // R3
  mret_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_kind) == K_MRET && $past(cur_priv) != PRIV_M)
      |-> (trap && trap_cause == C_ILLEGAL));

  // R6
  sret_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap && $past(req_kind) == K_SRET)
      |-> (m_status_o[B_SPIE] && !m_status_o[B_SPP]));

  // R7
  mret_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap && $past(req_kind) == K_MRET)
      |-> (m_status_o[B_MPIE] && !m_status_o[B_MPV] && !m_status_o[B_MELP]));

  // R10
  nmi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap && $past(req_kind) == K_NRET) |-> n_status_o[N_NMIE]);

  // R12
  selp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap && $past(req_kind) == K_SRET) |-> !m_status_o[B_SELP]);
endmodule

bind trap_return_unit tret_chk u_tret_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .cur_priv(cur_priv), .m_status_i(m_status_i), .out_valid(out_valid),
  .trap(trap), .trap_cause(trap_cause), .new_priv(new_priv),
  .m_status_o(m_status_o), .n_status_o(n_status_o)
);

// File: tb/tb_trap_return_unit.sv
module tb_trap_return_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0;
  logic [1:0] req_kind = 0, cur_priv = 3;
  logic cur_virt = 0;
  logic [13:0] m_i = 0;
  logic [1:0] h_i = 0;
  logic vs_i = 0;
  logic [4:0] n_i = 0;
  logic elp_i = 0;
  logic [XLEN-1:0] sepc = 0, mepc = 0, nepc = 0;
  logic rvc = 1, rvu = 1, rvh = 0, sdbl = 0, mdbl = 0, v112 = 0, pmpe = 0;
  logic [3:0] lpad = 0;

  logic out_valid, trap, vs_o, new_virt, elp_o;
  logic [4:0] cause, n_o;
  logic [1:0] new_priv, h_o;
  logic [13:0] m_o;
  logic [XLEN-1:0] ret_pc;

  trap_return_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .m_status_i(m_i),
    .h_status_i(h_i), .vs_sdt_i(vs_i), .n_status_i(n_i), .elp_i(elp_i),
    .s_epc_i(sepc), .m_epc_i(mepc), .n_epc_i(nepc), .cfg_rvc(rvc),
    .cfg_rvu(rvu), .cfg_rvh(rvh), .cfg_sdbl(sdbl), .cfg_mdbl(mdbl),
    .cfg_v112(v112), .cfg_pmp_empty(pmpe), .lpad_en(lpad),
    .out_valid(out_valid), .trap(trap), .trap_cause(cause),
    .new_priv(new_priv), .new_virt(new_virt), .m_status_o(m_o),
    .h_status_o(h_o), .vs_sdt_o(vs_o), .n_status_o(n_o), .elp_o(elp_o),
    .ret_pc(ret_pc)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected values
  logic e_trap, e_virt, e_vs, e_elp;
  logic [4:0] e_cause, e_n;
  logic [1:0] e_priv, e_h;
  logic [13:0] e_m;
  logic [XLEN-1:0] e_pc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  task automatic predict();
    logic [1:0] tgt;
    logic pv, saved, ok;
    e_pc = (req_kind == 0) ? sepc : (req_kind == 1) ? mepc : nepc;
    tgt = (req_kind == 1) ? m_i[6:5] : n_i[2:1];
    ok = (req_kind == 0) ? (cur_priv == 1 || cur_priv == 3)
       : (req_kind == 3) ? 1'b0 : (cur_priv == 3);
    e_trap = 1; e_cause = 2;
    if (!ok) e_cause = 2;
    else if (!rvc && e_pc[1:0] != 0) e_cause = 0;
    else if (req_kind == 0 && m_i[8] && cur_priv != 3) e_cause = 2;
    else if (req_kind == 0 && cur_virt && h_i[1]) e_cause = 22;
    else if (req_kind != 0 && pmpe && tgt != 3) e_cause = 1;
    else e_trap = 0;
    e_m = m_i; e_h = h_i; e_vs = vs_i; e_n = n_i;
    e_priv = cur_priv; e_virt = cur_virt; e_elp = elp_i;
    if (e_trap) return;
    e_cause = 0;
    if (req_kind == 0) begin
      e_priv = m_i[4] ? 2'd1 : 2'd0;
      e_m[0] = m_i[2]; e_m[2] = 1; e_m[4] = 0;
      pv = cur_virt;
      if (rvh && !cur_virt) begin pv = h_i[0]; e_h[0] = 0; end
      if (sdbl) begin
        e_m[10] = 0;
        if (rvh && !cur_virt && h_i[0] && !m_i[4]) e_vs = 0;
      end
      if (mdbl && cur_priv == 3) e_m[11] = 0;
      if (v112) e_m[7] = 0;
      saved = m_i[12]; e_m[12] = 0;
    end else begin
      e_priv = tgt;
      if (req_kind == 1) begin
        pv = m_i[9] && tgt != 3;
        e_m[1] = m_i[3]; e_m[3] = 1; e_m[6:5] = rvu ? 2'd0 : 2'd3; e_m[9] = 0;
        if (v112 && tgt != 3) e_m[7] = 0;
        if (mdbl) e_m[11] = 0;
        saved = m_i[13]; e_m[13] = 0;
      end else begin
        pv = n_i[3] && tgt != 3;
        e_n[0] = 1;
        if (tgt != 3) e_m[7] = 0;
        if (mdbl && tgt != 3) e_m[11] = 0;
        saved = n_i[4]; e_n[4] = 0;
      end
      if (sdbl && (tgt == 0 || (pv && tgt == 1))) e_m[10] = 0;
      if (sdbl && pv && tgt == 0) e_vs = 0;
    end
    e_virt = pv;
    if (lpad[e_priv]) e_elp = saved;
  endtask

  // One request: drive on the falling edge, sample at the next falling edge.
  task automatic run(input string tag);
    predict();
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " trap"}, trap, e_trap);
    chk({tag, " cause"}, cause, e_cause);
    chk({tag, " priv"}, new_priv, e_priv);
    chk({tag, " virt"}, new_virt, e_virt);
    chk({tag, " mstat"}, m_o, e_m);
    chk({tag, " hstat"}, h_o, e_h);
    chk({tag, " vsdt"}, vs_o, e_vs);
    chk({tag, " nstat"}, n_o, e_n);
    chk({tag, " elp"}, elp_o, e_elp);
    if (!e_trap) chk({tag, " pc"}, ret_pc, e_pc);
  endtask

  task automatic base();
    req_kind = 1; cur_priv = 3; cur_virt = 0; m_i = 0; h_i = 0; vs_i = 0;
    n_i = 0; elp_i = 0; sepc = 32'h100; mepc = 32'h200; nepc = 32'h300;
    rvc = 1; rvu = 1; rvh = 0; sdbl = 0; mdbl = 0; v112 = 0; pmpe = 0; lpad = 0;
  endtask

  function automatic logic [1:0] rpriv();
    case ($urandom % 3)
      0: return 2'd0;
      1: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    base();
    repeat (2) @(negedge clk);
    chk("R14 valid after reset", out_valid, 0);
    chk("R14 trap after reset", trap, 0);
    rst_n = 1;

    // R3 / R13
    base(); req_kind = 0; cur_priv = 0; m_i = 14'h3fff; run("R3 sret from U");
    base(); req_kind = 1; cur_priv = 1; m_i = 14'h1555; run("R3 mret from S");
    base(); req_kind = 2; cur_priv = 0; elp_i = 1; run("R13 nret hold");
    // R1 reserved flavour
    base(); req_kind = 3; run("R1 reserved kind");
    // R4
    base(); rvc = 0; mepc = 32'h202; run("R4 misaligned");
    base(); rvc = 1; mepc = 32'h202; run("R4 rvc aligned ok");
    // R5
    base(); req_kind = 0; cur_priv = 1; m_i[8] = 1; h_i[1] = 1; cur_virt = 1; run("R5 tsr");
    base(); req_kind = 0; cur_priv = 1; cur_virt = 1; h_i[1] = 1; run("R5 vtsr");
    base(); req_kind = 0; cur_priv = 3; m_i[8] = 1; run("R5 tsr in M");
    // R6 / R9
    base(); req_kind = 0; cur_priv = 1; m_i = 14'b00_0000_1001_0100; v112 = 1; run("R6 sret fields");
    base(); req_kind = 0; m_i[7] = 1; v112 = 0; run("R9 sret keep mprv");
    // R7 / R8 / R9
    base(); rvu = 0; m_i[6:5] = 1; m_i[3] = 1; m_i[9] = 1; m_i[7] = 1; v112 = 1; run("R7 mret no U");
    base(); m_i[6:5] = 3; m_i[9] = 1; m_i[7] = 1; v112 = 1; run("R8 mret to M");
    base(); req_kind = 0; rvh = 1; h_i[0] = 1; m_i[4] = 1; run("R8 sret spv");
    base(); req_kind = 2; n_i = 5'b01011; m_i[7] = 1; run("R9 nret mprv");
    // R10
    base(); req_kind = 2; n_i[2:1] = 0; run("R10 nmie");
    base(); req_kind = 2; pmpe = 1; n_i[2:1] = 1; run("R10 pmp fault");
    base(); req_kind = 1; pmpe = 1; m_i[6:5] = 3; run("R10 pmp to M ok");
    // R11
    base(); sdbl = 1; mdbl = 1; m_i[6:5] = 0; m_i[9] = 1; m_i[11:10] = 2'b11; vs_i = 1; run("R11 mret VU");
    base(); sdbl = 1; m_i[6:5] = 1; m_i[10] = 1; vs_i = 1; run("R11 mret S keep");
    base(); req_kind = 0; sdbl = 1; mdbl = 1; rvh = 1; h_i[0] = 1; m_i[11:10] = 2'b11; vs_i = 1; run("R11 sret VU");
    // R12
    base(); req_kind = 2; n_i = 5'b10001; lpad = 4'b0001; run("R12 restore");
    base(); m_i[13] = 1; elp_i = 0; lpad = 4'b0001; m_i[6:5] = 3; run("R12 disabled");

    // R2 strobe drops
    @(negedge clk);
    chk("R2 valid pulse ends", out_valid, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      req_kind = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      cur_priv = ($urandom % 2) ? 2'd3 : rpriv();
      cur_virt = $urandom; m_i = $urandom; m_i[6:5] = rpriv();
      h_i = $urandom; vs_i = $urandom; n_i = $urandom; n_i[2:1] = rpriv();
      elp_i = $urandom; sepc = $urandom; mepc = $urandom; nepc = $urandom;
      rvc = ($urandom % 4) != 0; rvu = $urandom; rvh = $urandom;
      sdbl = $urandom; mdbl = $urandom; v112 = $urandom;
      pmpe = ($urandom % 5) == 0; lpad = $urandom;
      if ($urandom % 3 != 0) m_i[8] = 0;
      if ($urandom % 3 != 0) h_i[1] = 0;
      run("R13 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule